// File: doc/BRIEF.md
# Video Display Timing Generator

This block produces the line and field framing for an analog component video output path. A pixel counter and a line counter run on the incoming pixel clock. They are locked to reference sync, which comes either from discrete horizontal, vertical and field reference inputs or from H, V and F flags already decoded out of an embedded-sync pixel stream. A single select input chooses the source. From the counter position and a set of programmed horizontal and vertical positions, the block decides for every pixel which word each converter channel receives.

That word is one of the following, in priority order:
- the negative sync level,
- the positive sync level, which gives tri-level sync when a positive segment is programmed,
- a pulse level for standard-definition equalization and serration or for high-definition broad pulses,
- the blank level,
- the pass-through of active pixel data.

An active-video flag, the pixel and line position and the captured field identifier are presented alongside the level word. All of these outputs are registered together, so they describe the same pixel.

The amplitudes are per-channel programmable words, so sync can be placed on any subset of channels. A mode input selects between standard-definition vertical interval shaping and high-definition shaping:
- In standard-definition mode, equalization lines and serrated vertical sync lines replace the normal line sync.
- In high-definition mode, the line sync stays in place and a broad pulse is added on the vertical sync lines.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, and for the two clocks after its release that the internal reset synchronizer takes, the level word, active flag, pixel and line outputs and field output are all zero.
- R2: The pixel counter counts 0 up to line_len-1 and then returns to 0. Each return to 0 advances the line counter, which wraps from frame_lines-1 to 0.
- R3: A rising edge of the selected horizontal reference, seen at a clock edge, forces the pixel counter to 0 at that edge and advances the line counter.
- R4: A rising edge of the selected vertical reference forces the line counter to 0 and loads the selected field flag into field_out at the same edge.
- R5: ref_sel=0 takes the discrete references href_in, vref_in and fref_in. ref_sel=1 takes emb_hflag, emb_vflag and emb_fflag. The unselected group has no effect on the outputs.
- R6: active_out is 1 exactly when act_h_start <= pixel < act_h_end and act_v_start <= line < act_v_end.
- R7: On a line without standard-definition vertical shaping, pixels with hs_neg_start <= pixel < hs_neg_end output the lvl_neg word on every channel.
- R8: On such a line, pixels with hs_neg_end <= pixel < hs_pos_end output lvl_pos (tri-level sync). The segment is empty when hs_pos_end <= hs_neg_end.
- R9: Standard-definition mode (hd_mode=0), equalization lines (eq_pre_start <= line < vs_start or vs_end <= line < eq_post_end): line sync is suppressed and lvl_pulse is output for pixel < eq_width and for half <= pixel < half+eq_width, where half = line_len/2 rounded down.
- R10: Standard-definition mode, vertical sync lines (vs_start <= line < vs_end): line sync is suppressed and lvl_pulse is output for pixel < half-serr_width and for half <= pixel < line_len-serr_width.
- R11: High-definition mode (hd_mode=1): equalization lines behave as normal lines. Vertical sync lines keep line sync and output lvl_pulse for brd_start <= pixel < brd_end wherever no sync segment applies.
- R12: Pixels covered by no sync or pulse segment output lvl_blank outside the active window and pix_data inside it.
- R13: All outputs come out of one register stage. px_out and ln_out are the counter values that the level word and active flag of the same cycle were computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 1 | Reference source: 0 discrete, 1 embedded flags |
| hd_mode | input | 1 | 1 selects high-definition vertical shaping |
| href_in | input | 1 | Discrete horizontal reference |
| vref_in | input | 1 | Discrete vertical reference |
| fref_in | input | 1 | Discrete field reference |
| emb_hflag | input | 1 | Decoded embedded H flag |
| emb_vflag | input | 1 | Decoded embedded V flag |
| emb_fflag | input | 1 | Decoded embedded F flag |
| line_len | input | CW | Total pixels per line |
| frame_lines | input | CW | Total lines per frame |
| act_h_start | input | CW | First active pixel |
| act_h_end | input | CW | Pixel after the last active one |
| act_v_start | input | CW | First active line |
| act_v_end | input | CW | Line after the last active one |
| hs_neg_start | input | CW | Start of negative line sync |
| hs_neg_end | input | CW | End of negative sync, start of positive sync |
| hs_pos_end | input | CW | End of positive sync |
| eq_width | input | CW | Equalization pulse width |
| serr_width | input | CW | Serration gap width |
| brd_start | input | CW | High-definition broad pulse start |
| brd_end | input | CW | High-definition broad pulse end |
| eq_pre_start | input | CW | First pre-equalization line |
| vs_start | input | CW | First vertical sync line |
| vs_end | input | CW | Line after the last vertical sync line |
| eq_post_end | input | CW | Line after the last post-equalization line |
| lvl_neg | input | NCH*DW | Negative sync word per channel |
| lvl_pos | input | NCH*DW | Positive sync word per channel |
| lvl_pulse | input | NCH*DW | Equalization, serration and broad pulse word per channel |
| lvl_blank | input | NCH*DW | Blank word per channel |
| pix_data | input | NCH*DW | Active pixel data per channel |
| lvl_out | output | NCH*DW | Level word to the converters |
| active_out | output | 1 | Active-video flag |
| px_out | output | CW | Pixel position |
| ln_out | output | CW | Line position |
| field_out | output | 1 | Captured field identifier |

## Verification
The bench first lets the counters free-run in standard-definition mode with no references. This separates wrap behaviour and the full priority map (line sync, equalization, serration, blank, data) from any locking effect. Discrete horizontal and vertical pulses at off-grid pixel positions then show that the counters re-lock and that the field flag is captured. In the embedded-source phase the discrete pins toggle freely while only the embedded flags move, which tells a correct source select from one that leaks the other group. A high-definition phase and a phase with an empty positive segment tell broad-pulse shaping from serration and tri-level sync from bi-level sync.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [2:0] {
    LV_DATA  = 3'd0,
    LV_BLANK = 3'd1,
    LV_PULSE = 3'd2,
    LV_POS   = 3'd3,
    LV_NEG   = 3'd4
  } lvl_sel_e;

endpackage

// File: rtl/dtg_ref_sel.sv
module dtg_ref_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_sel,
  input  logic href_in,
  input  logic vref_in,
  input  logic fref_in,
  input  logic emb_hflag,
  input  logic emb_vflag,
  input  logic emb_fflag,
  output logic h_edge,
  output logic v_edge,
  output logic field_o
);

  logic h_s, v_s, f_s;
  logic h_q, v_q, field_q;
  logic h_d, v_d, field_d;

  always_comb begin
    h_s     = ref_sel ? emb_hflag : href_in;
    v_s     = ref_sel ? emb_vflag : vref_in;
    f_s     = ref_sel ? emb_fflag : fref_in;
    h_edge  = h_s & ~h_q;
    v_edge  = v_s & ~v_q;
    h_d     = h_s;
    v_d     = v_s;
    field_d = v_edge ? f_s : field_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q     <= 1'b0;
      v_q     <= 1'b0;
      field_q <= 1'b0;
    end else begin
      h_q     <= h_d;
      v_q     <= v_d;
      field_q <= field_d;
    end
  end

  assign field_o = field_q;

  // R4: field flag taken on the vertical edge
  p_field_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (field_q == $past(f_s)));

endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] frame_lines,
  input  logic          h_edge,
  input  logic          v_edge,
  output logic [CW-1:0] px,
  output logic [CW-1:0] ln
);

  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic [CW-1:0] px_q, ln_q, px_d, ln_d;
  logic          px_wrap, ln_last, adv;

  always_comb begin
    px_wrap = (px_q == (line_len - C_ONE));
    ln_last = (ln_q == (frame_lines - C_ONE));
    adv     = px_wrap | h_edge;
    px_d    = adv ? '0 : (px_q + C_ONE);
    if (v_edge)       ln_d = '0;
    else if (!adv)    ln_d = ln_q;
    else if (ln_last) ln_d = '0;
    else              ln_d = ln_q + C_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q <= '0;
      ln_q <= '0;
    end else begin
      px_q <= px_d;
      ln_q <= ln_d;
    end
  end

  assign px = px_q;
  assign ln = ln_q;

  // R2: pixel counter returns to zero after the last pixel
  p_px_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (px_q == (line_len - C_ONE)) |=> (px_q == '0));

  // R3: horizontal reference edge restarts the line
  p_href_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_edge |=> (px_q == '0));

  // R4: vertical reference edge restarts the frame
  p_vref_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (ln_q == '0));

endmodule

// File: rtl/dtg_region.sv
module dtg_region
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          hd_mode,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] ln,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] act_h_start,
  input  logic [CW-1:0] act_h_end,
  input  logic [CW-1:0] act_v_start,
  input  logic [CW-1:0] act_v_end,
  input  logic [CW-1:0] hs_neg_start,
  input  logic [CW-1:0] hs_neg_end,
  input  logic [CW-1:0] hs_pos_end,
  input  logic [CW-1:0] eq_width,
  input  logic [CW-1:0] serr_width,
  input  logic [CW-1:0] brd_start,
  input  logic [CW-1:0] brd_end,
  input  logic [CW-1:0] eq_pre_start,
  input  logic [CW-1:0] vs_start,
  input  logic [CW-1:0] vs_end,
  input  logic [CW-1:0] eq_post_end,
  output lvl_sel_e      sel,
  output logic          active
);

  logic [CW-1:0] half;
  logic [CW:0]   half_eq_end;
  logic [CW-1:0] serr_a_end, serr_b_end;
  logic          in_pre, in_post, vs_line, eq_line, sd_shape;
  logic          hs_neg, hs_pos, eq_pulse, serr_pulse, brd_pulse, pulse;
  logic          neg, pos, h_win, v_win;

  always_comb begin
    half        = {1'b0, line_len[CW-1:1]};
    half_eq_end = {1'b0, half} + {1'b0, eq_width};
    serr_a_end  = half - serr_width;
    serr_b_end  = line_len - serr_width;

    in_pre   = (ln >= eq_pre_start) && (ln < vs_start);
    in_post  = (ln >= vs_end) && (ln < eq_post_end);
    vs_line  = (ln >= vs_start) && (ln < vs_end);
    eq_line  = in_pre || in_post;
    sd_shape = !hd_mode && (eq_line || vs_line);

    hs_neg     = (px >= hs_neg_start) && (px < hs_neg_end);
    hs_pos     = (px >= hs_neg_end) && (px < hs_pos_end);
    eq_pulse   = (px < eq_width) ||
                 ((px >= half) && ({1'b0, px} < half_eq_end));
    serr_pulse = (px < serr_a_end) || ((px >= half) && (px < serr_b_end));
    brd_pulse  = (px >= brd_start) && (px < brd_end);

    if (hd_mode) pulse = vs_line && brd_pulse;
    else         pulse = (eq_line && eq_pulse) || (vs_line && serr_pulse);

    neg = hs_neg && !sd_shape;
    pos = hs_pos && !sd_shape;

    h_win  = (px >= act_h_start) && (px < act_h_end);
    v_win  = (ln >= act_v_start) && (ln < act_v_end);
    active = h_win && v_win;

    if (neg)          sel = LV_NEG;
    else if (pos)     sel = LV_POS;
    else if (pulse)   sel = LV_PULSE;
    else if (!active) sel = LV_BLANK;
    else              sel = LV_DATA;
  end

endmodule

// File: rtl/dtg_level_mux.sv
module dtg_level_mux
  import dtg_pkg::*;
#(
  parameter int CW  = 12,
  parameter int DW  = 10,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lvl_sel_e          sel,
  input  logic              active_in,
  input  logic [CW-1:0]     px_in,
  input  logic [CW-1:0]     ln_in,
  input  logic [NCH*DW-1:0] lvl_neg,
  input  logic [NCH*DW-1:0] lvl_pos,
  input  logic [NCH*DW-1:0] lvl_pulse,
  input  logic [NCH*DW-1:0] lvl_blank,
  input  logic [NCH*DW-1:0] pix_data,
  output logic [NCH*DW-1:0] lvl_o,
  output logic              active_o,
  output logic [CW-1:0]     px_o,
  output logic [CW-1:0]     ln_o
);

  logic [NCH*DW-1:0] lvl_d, lvl_q;
  logic              act_q;
  logic [CW-1:0]     px_q, ln_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      unique case (sel)
        LV_NEG:   lvl_d[c*DW +: DW] = lvl_neg[c*DW +: DW];
        LV_POS:   lvl_d[c*DW +: DW] = lvl_pos[c*DW +: DW];
        LV_PULSE: lvl_d[c*DW +: DW] = lvl_pulse[c*DW +: DW];
        LV_BLANK: lvl_d[c*DW +: DW] = lvl_blank[c*DW +: DW];
        default:  lvl_d[c*DW +: DW] = pix_data[c*DW +: DW];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      act_q <= 1'b0;
      px_q  <= '0;
      ln_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      act_q <= active_in;
      px_q  <= px_in;
      ln_q  <= ln_in;
    end
  end

  assign lvl_o    = lvl_q;
  assign active_o = act_q;
  assign px_o     = px_q;
  assign ln_o     = ln_q;

  // R7: negative sync selection reaches the output one clock later
  p_neg_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == LV_NEG) |=> (lvl_q == $past(lvl_neg)));

  // R12: blank selection reaches the output one clock later
  p_blank_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == LV_BLANK) |=> (lvl_q == $past(lvl_blank)));

  // R13: position outputs follow the counters by one register
  p_pos_align_r13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (px_q == $past(px_in)) && (ln_q == $past(ln_in)));

endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int CW  = 12,
  parameter int DW  = 10,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_sel,
  input  logic              hd_mode,
  input  logic              href_in,
  input  logic              vref_in,
  input  logic              fref_in,
  input  logic              emb_hflag,
  input  logic              emb_vflag,
  input  logic              emb_fflag,
  input  logic [CW-1:0]     line_len,
  input  logic [CW-1:0]     frame_lines,
  input  logic [CW-1:0]     act_h_start,
  input  logic [CW-1:0]     act_h_end,
  input  logic [CW-1:0]     act_v_start,
  input  logic [CW-1:0]     act_v_end,
  input  logic [CW-1:0]     hs_neg_start,
  input  logic [CW-1:0]     hs_neg_end,
  input  logic [CW-1:0]     hs_pos_end,
  input  logic [CW-1:0]     eq_width,
  input  logic [CW-1:0]     serr_width,
  input  logic [CW-1:0]     brd_start,
  input  logic [CW-1:0]     brd_end,
  input  logic [CW-1:0]     eq_pre_start,
  input  logic [CW-1:0]     vs_start,
  input  logic [CW-1:0]     vs_end,
  input  logic [CW-1:0]     eq_post_end,
  input  logic [NCH*DW-1:0] lvl_neg,
  input  logic [NCH*DW-1:0] lvl_pos,
  input  logic [NCH*DW-1:0] lvl_pulse,
  input  logic [NCH*DW-1:0] lvl_blank,
  input  logic [NCH*DW-1:0] pix_data,
  output logic [NCH*DW-1:0] lvl_out,
  output logic              active_out,
  output logic [CW-1:0]     px_out,
  output logic [CW-1:0]     ln_out,
  output logic              field_out
);

  logic [1:0]    rsync_q;
  logic          rst_i;
  logic          h_edge, v_edge;
  logic [CW-1:0] px, ln;
  lvl_sel_e      sel;
  logic          active;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  dtg_ref_sel u_ref (
    .clk       (clk),
    .rst_n     (rst_i),
    .ref_sel   (ref_sel),
    .href_in   (href_in),
    .vref_in   (vref_in),
    .fref_in   (fref_in),
    .emb_hflag (emb_hflag),
    .emb_vflag (emb_vflag),
    .emb_fflag (emb_fflag),
    .h_edge    (h_edge),
    .v_edge    (v_edge),
    .field_o   (field_out)
  );

  dtg_counters #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_i),
    .line_len    (line_len),
    .frame_lines (frame_lines),
    .h_edge      (h_edge),
    .v_edge      (v_edge),
    .px          (px),
    .ln          (ln)
  );

  dtg_region #(.CW(CW)) u_reg (
    .hd_mode      (hd_mode),
    .px           (px),
    .ln           (ln),
    .line_len     (line_len),
    .act_h_start  (act_h_start),
    .act_h_end    (act_h_end),
    .act_v_start  (act_v_start),
    .act_v_end    (act_v_end),
    .hs_neg_start (hs_neg_start),
    .hs_neg_end   (hs_neg_end),
    .hs_pos_end   (hs_pos_end),
    .eq_width     (eq_width),
    .serr_width   (serr_width),
    .brd_start    (brd_start),
    .brd_end      (brd_end),
    .eq_pre_start (eq_pre_start),
    .vs_start     (vs_start),
    .vs_end       (vs_end),
    .eq_post_end  (eq_post_end),
    .sel          (sel),
    .active       (active)
  );

  dtg_level_mux #(.CW(CW), .DW(DW), .NCH(NCH)) u_mux (
    .clk       (clk),
    .rst_n     (rst_i),
    .sel       (sel),
    .active_in (active),
    .px_in     (px),
    .ln_in     (ln),
    .lvl_neg   (lvl_neg),
    .lvl_pos   (lvl_pos),
    .lvl_pulse (lvl_pulse),
    .lvl_blank (lvl_blank),
    .pix_data  (pix_data),
    .lvl_o     (lvl_out),
    .active_o  (active_out),
    .px_o      (px_out),
    .ln_o      (ln_out)
  );

  // R6: active flag never raised on a line outside the vertical window
  p_active_vwin_r6: assert property (@(posedge clk) disable iff (!rst_i)
    active_out |-> (ln_out >= act_v_start) && (ln_out < act_v_end));

endmodule

// File: tb/tb_dtg_top.sv
module tb_dtg_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 12;
  localparam int DW  = 10;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_sel = 1'b0, hd_mode = 1'b0;
  logic href_in = 1'b0, vref_in = 1'b0, fref_in = 1'b0;
  logic emb_hflag = 1'b0, emb_vflag = 1'b0, emb_fflag = 1'b0;
  logic [CW-1:0] line_len = 40, frame_lines = 20;
  logic [CW-1:0] act_h_start = 10, act_h_end = 36, act_v_start = 5, act_v_end = 18;
  logic [CW-1:0] hs_neg_start = 0, hs_neg_end = 4, hs_pos_end = 8;
  logic [CW-1:0] eq_width = 2, serr_width = 3, brd_start = 12, brd_end = 30;
  logic [CW-1:0] eq_pre_start = 1, vs_start = 2, vs_end = 3, eq_post_end = 4;
  logic [NCH*DW-1:0] lvl_neg, lvl_pos, lvl_pulse, lvl_blank, pix_data = '0;
  logic [NCH*DW-1:0] lvl_out;
  logic active_out, field_out;
  logic [CW-1:0] px_out, ln_out;

  int total = 0, bad = 0, edges = 0, rcnt = 0;
  int m_px = 0, m_ln = 0, m_hq = 0, m_vq = 0;
  int e_px = 0, e_ln = 0, e_act = 0, e_fld = 0, e_cat = 0, e_tag = 0;
  logic [NCH*DW-1:0] e_lvl = '0;
  string phase = "reset";
  bit finished = 0;

  dtg_top #(.CW(CW), .DW(DW), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .hd_mode(hd_mode),
    .href_in(href_in), .vref_in(vref_in), .fref_in(fref_in),
    .emb_hflag(emb_hflag), .emb_vflag(emb_vflag), .emb_fflag(emb_fflag),
    .line_len(line_len), .frame_lines(frame_lines),
    .act_h_start(act_h_start), .act_h_end(act_h_end),
    .act_v_start(act_v_start), .act_v_end(act_v_end),
    .hs_neg_start(hs_neg_start), .hs_neg_end(hs_neg_end), .hs_pos_end(hs_pos_end),
    .eq_width(eq_width), .serr_width(serr_width),
    .brd_start(brd_start), .brd_end(brd_end),
    .eq_pre_start(eq_pre_start), .vs_start(vs_start), .vs_end(vs_end),
    .eq_post_end(eq_post_end),
    .lvl_neg(lvl_neg), .lvl_pos(lvl_pos), .lvl_pulse(lvl_pulse),
    .lvl_blank(lvl_blank), .pix_data(pix_data),
    .lvl_out(lvl_out), .active_out(active_out), .px_out(px_out),
    .ln_out(ln_out), .field_out(field_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < NCH; c++) begin
      lvl_neg[c*DW +: DW]   = DW'(16*c + 1);
      lvl_pos[c*DW +: DW]   = DW'(16*c + 2);
      lvl_pulse[c*DW +: DW] = DW'(16*c + 3);
      lvl_blank[c*DW +: DW] = DW'(16*c + 4);
    end
  end

  always @(negedge clk) pix_data <= NCH*DW'($urandom);

  // category: 0 data, 1 blank, 2 pulse, 3 positive sync, 4 negative sync
  function automatic int cat_of(input int px, input int ln, output int tag);
    int half, L;
    bit vsl, eql, sd, neg, pos, pul, act;
    L    = int'(line_len);
    half = L / 2;
    vsl  = (ln >= int'(vs_start)) && (ln < int'(vs_end));
    eql  = ((ln >= int'(eq_pre_start)) && (ln < int'(vs_start))) ||
           ((ln >= int'(vs_end)) && (ln < int'(eq_post_end)));
    sd   = !hd_mode && (vsl || eql);
    neg  = !sd && (px >= int'(hs_neg_start)) && (px < int'(hs_neg_end));
    pos  = !sd && (px >= int'(hs_neg_end)) && (px < int'(hs_pos_end));
    if (hd_mode) begin
      pul = vsl && (px >= int'(brd_start)) && (px < int'(brd_end));
      tag = 11;
    end else if (eql) begin
      pul = (px < int'(eq_width)) || ((px >= half) && (px < half + int'(eq_width)));
      tag = 9;
    end else begin
      pul = vsl && ((px < half - int'(serr_width)) ||
                    ((px >= half) && (px < L - int'(serr_width))));
      tag = 10;
    end
    act = (px >= int'(act_h_start)) && (px < int'(act_h_end)) &&
          (ln >= int'(act_v_start)) && (ln < int'(act_v_end));
    if (neg) return 4;
    if (pos) return 3;
    if (pul) return 2;
    if (!act) return 1;
    return 0;
  endfunction

  function automatic string cat_req(input int cat, input int tag);
    case (cat)
      4: return "R7";
      3: return "R8";
      2: return (tag == 11) ? "R11" : ((tag == 9) ? "R9" : "R10");
      default: return "R12";
    endcase
  endfunction

  // reference model and per-clock comparison
  always @(posedge clk) begin
    int hs, vs, fs, he, ve, adv, ptag;
    edges++;
    if (!rst_n) begin
      rcnt = 0; m_px = 0; m_ln = 0; m_hq = 0; m_vq = 0;
      e_px = 0; e_ln = 0; e_act = 0; e_fld = 0; e_lvl = '0; e_cat = 1;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      e_cat = cat_of(m_px, m_ln, ptag);
      e_tag = ptag;
      for (int c = 0; c < NCH; c++) begin
        case (e_cat)
          4: e_lvl[c*DW +: DW] = lvl_neg[c*DW +: DW];
          3: e_lvl[c*DW +: DW] = lvl_pos[c*DW +: DW];
          2: e_lvl[c*DW +: DW] = lvl_pulse[c*DW +: DW];
          1: e_lvl[c*DW +: DW] = lvl_blank[c*DW +: DW];
          default: e_lvl[c*DW +: DW] = pix_data[c*DW +: DW];
        endcase
      end
      e_act = (m_px >= int'(act_h_start)) && (m_px < int'(act_h_end)) &&
              (m_ln >= int'(act_v_start)) && (m_ln < int'(act_v_end));
      e_px = m_px;
      e_ln = m_ln;
      hs = ref_sel ? int'(emb_hflag) : int'(href_in);
      vs = ref_sel ? int'(emb_vflag) : int'(vref_in);
      fs = ref_sel ? int'(emb_fflag) : int'(fref_in);
      he = hs && !m_hq;
      ve = vs && !m_vq;
      if (ve) e_fld = fs;
      adv = (m_px == int'(line_len) - 1) || he;
      m_px = adv ? 0 : m_px + 1;
      if (ve) m_ln = 0;
      else if (adv) m_ln = (m_ln == int'(frame_lines) - 1) ? 0 : m_ln + 1;
      m_hq = hs;
      m_vq = vs;
    end
    #2;
    if (edges >= 3 && !finished) begin
      if (!rst_n || rcnt < 2) begin
        // R1 reset state
        total++;
        if (lvl_out !== '0 || active_out !== 1'b0 || px_out !== '0 ||
            ln_out !== '0 || field_out !== 1'b0) begin
          bad++;
          $display("FAIL R1 [%s] lvl=%h act=%b px=%0d ln=%0d fld=%b exp all zero",
                   phase, lvl_out, active_out, px_out, ln_out, field_out);
        end
      end else begin
        total++;
        if (int'(px_out) != e_px) begin
          bad++;
          $display("FAIL R2 R3 R13 [%s] px_out=%0d exp=%0d", phase, px_out, e_px);
        end
        if (int'(ln_out) != e_ln) begin
          bad++;
          $display("FAIL R2 R4 [%s] ln_out=%0d exp=%0d", phase, ln_out, e_ln);
        end
        if (int'(field_out) != e_fld) begin
          bad++;
          $display("FAIL R4 [%s] field_out=%b exp=%0d", phase, field_out, e_fld);
        end
        if (int'(active_out) != e_act) begin
          bad++;
          $display("FAIL R6 [%s] active_out=%b exp=%0d at px=%0d ln=%0d",
                   phase, active_out, e_act, e_px, e_ln);
        end
        if (lvl_out !== e_lvl) begin
          bad++;
          $display("FAIL %s [%s] lvl_out=%h exp=%h at px=%0d ln=%0d",
                   cat_req(e_cat, e_tag), phase, lvl_out, e_lvl, e_px, e_ln);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_disc(input bit h, input bit v, input bit f);
    @(negedge clk);
    if (h) href_in = 1'b1;
    if (v) begin vref_in = 1'b1; fref_in = f; end
    @(negedge clk);
    href_in = 1'b0;
    vref_in = 1'b0;
  endtask

  task automatic pulse_emb(input bit h, input bit v, input bit f);
    @(negedge clk);
    if (h) emb_hflag = 1'b1;
    if (v) begin emb_vflag = 1'b1; emb_fflag = f; end
    @(negedge clk);
    emb_hflag = 1'b0;
    emb_vflag = 1'b0;
  endtask

  initial begin
    wait_clk(6);
    rst_n = 1'b1;
    phase = "R2 R7 R8 R9 R10 R12 sd free run";
    wait_clk(1700);

    phase = "R3 R4 discrete lock";
    wait_clk(13);
    pulse_disc(1, 0, 0);
    wait_clk(57);
    pulse_disc(1, 0, 0);
    wait_clk(201);
    pulse_disc(0, 1, 1);
    wait_clk(333);
    pulse_disc(1, 1, 0);
    wait_clk(900);
    pulse_disc(0, 1, 1);
    wait_clk(400);

    phase = "R5 embedded source";
    ref_sel = 1'b1;
    wait_clk(50);
    for (int k = 0; k < 30; k++) begin
      pulse_disc(1, (k % 3) == 0, k[0]);
      wait_clk(7 + k);
    end
    pulse_emb(1, 0, 0);
    wait_clk(123);
    pulse_emb(0, 1, 1);
    wait_clk(517);
    pulse_emb(1, 1, 0);
    wait_clk(900);

    phase = "R11 hd broad pulses";
    ref_sel = 1'b0;
    hd_mode = 1'b1;
    wait_clk(1700);

    phase = "R8 R12 bi-level sync";
    hd_mode = 1'b0;
    hs_pos_end = 3;
    wait_clk(1700);

    finished = 1;
    wait_clk(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule